// File: doc/BRIEF.md
# Drawing Coprocessor Host Register Interface

This block is the CPU-facing side of a bitmap drawing coprocessor. An 8-bit host bus with a 4-bit offset loads a 16-bit index word, a command byte, three colour-plane bytes and an X/Y position pair, plus two scroll bytes and a control byte. The bytes are presented as steady outputs to the drawing engines. Each command code is launched by the write of one particular parameter register. When that write happens, the block emits a one-cycle start pulse together with the 3-bit code. This lets software load the other operands in any order and fire the operation with its final store.

The block also collects events from the rest of the video system. It keeps latched foreground and background collision reports with their coordinates, and a pending flag for the frame-blank pulse. It exposes these flags through an active-low status byte and a single interrupt line. A coordinate read acknowledges its collision. The frame-blank flag is acknowledged by a write strobe.

Top module: `gfx_host_regs`

## Requirements
- R1: Writes store byte data by offset: 0 low half of the index word, 1 high half, 2 command, 3 green, 4 X, 5 Y, 6 red, 7 blue, 8 horizontal scroll, 9 vertical scroll, 10 control. Each value appears on its output port on the cycle after the write.
- R2: Writing the command register (offset 2) with data bits 2:0 equal to 6 raises `start` for exactly one cycle, with `start_code` = 6. `start` rises in the cycle after the write.
- R3: Where the stored command code (command bits 2:0) is 3, 4, 5, 2 or 7, a start pulse with that code follows a write to offset 4, 5, 1, 7 or 7 respectively. A write to any other offset does not start that code. A write to offset 2 with a code other than 6 starts nothing.
- R4: Codes 0 and 1 never produce a start pulse, whichever register is written.
- R5: Read offset 0 returns the foreground collision X coordinate. Read offset 1 returns its Y coordinate and clears the foreground pending flag.
- R6: Read offset 2 returns the background collision X coordinate with bits 1:0 forced to 0. Read offset 3 returns the background Y coordinate and clears the background pending flag.
- R7: Read offset 4 returns status: bit 7 engine busy, bit 6 NOT foreground pending, bit 5 NOT frame-blank pending, bit 4 NOT background pending, bit 3 the scanline bit 8 input, bits 2:0 zero.
- R8: `irq` is high exactly when frame-blank is pending, or foreground collision is pending, or background collision is pending while control bit 5 is 1.
- R9: A frame-blank pulse sets the frame-blank pending flag. Any write to offset 11 clears it. If both happen in the same cycle, the flag is set.
- R10: A foreground collision report is taken only while none is pending. Later reports leave the held coordinates unchanged until offset 1 is read.
- R11: Read offsets 5 to 15 return 0. Reset clears every parameter, the scroll and control bytes, all flags, `start` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| eng_busy | input | 1 | Drawing engine busy |
| scan_line8 | input | 1 | Bit 8 of current scanline |
| vblank_pulse | input | 1 | Frame-blank event |
| fg_hit | input | 1 | Foreground collision report |
| fg_hit_x | input | 8 | Foreground collision X |
| fg_hit_y | input | 8 | Foreground collision Y |
| bg_hit | input | 1 | Background collision report |
| bg_hit_x | input | 8 | Background collision X |
| bg_hit_y | input | 8 | Background collision Y |
| prm_index | output | 16 | Index word |
| prm_cmd | output | 8 | Command byte |
| prm_green | output | 8 | Green plane byte |
| prm_x | output | 8 | X position |
| prm_y | output | 8 | Y position |
| prm_red | output | 8 | Red plane byte |
| prm_blue | output | 8 | Blue plane byte |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| ctrl | output | 8 | Control byte |
| start | output | 1 | One-cycle command launch |
| start_code | output | 3 | Code of the launched command |
| irq | output | 1 | Combined interrupt |

## Verification
The trigger decoder is exercised with write sequences for each code. For every code, its own trigger register is written, and so is at least one register that triggers a different code. This separates a correct per-code pairing from a decoder that fires on any parameter write. Codes 0 and 1 are driven through every trigger register to show they stay silent. The event side is checked in several ways. Repeated foreground reports show whether the first coordinates are held. Toggling control bit 5 with a background event pending shows whether the enable gates only that source. A frame-blank pulse is applied in the same cycle as the clear strobe to pin down which one wins.

// File: rtl/hrif_pkg.sv
package hrif_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    WO_IDX_LO = 4'd0,
    WO_IDX_HI = 4'd1,
    WO_CMD    = 4'd2,
    WO_GREEN  = 4'd3,
    WO_XPOS   = 4'd4,
    WO_YPOS   = 4'd5,
    WO_RED    = 4'd6,
    WO_BLUE   = 4'd7,
    WO_SCX    = 4'd8,
    WO_SCY    = 4'd9,
    WO_CTRL   = 4'd10,
    WO_VCLR   = 4'd11
  } wr_ofs_e;

  localparam logic [REG_AW-1:0] RO_FG_X  = 4'd0;
  localparam logic [REG_AW-1:0] RO_FG_Y  = 4'd1;
  localparam logic [REG_AW-1:0] RO_BG_X  = 4'd2;
  localparam logic [REG_AW-1:0] RO_BG_Y  = 4'd3;
  localparam logic [REG_AW-1:0] RO_STAT  = 4'd4;

  typedef enum logic [2:0] {
    OP_IDLE0  = 3'd0,
    OP_IDLE1  = 3'd1,
    OP_FILL   = 3'd2,
    OP_SPRITE = 3'd3,
    OP_RUN    = 3'd4,
    OP_LINE   = 3'd5,
    OP_MOVE   = 3'd6,
    OP_PLOT   = 3'd7
  } op_code_e;

  localparam int unsigned ST_BUSY   = 7;
  localparam int unsigned ST_FG_N   = 6;
  localparam int unsigned ST_VB_N   = 5;
  localparam int unsigned ST_BG_N   = 4;
  localparam int unsigned ST_LINE8  = 3;
  localparam int unsigned CTL_BG_EN = 5;
  localparam int unsigned BGX_DROP  = 2;
endpackage

// File: rtl/hrif_param_bank.sv
module hrif_param_bank
  import hrif_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CW = 3,
  localparam int IW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [IW-1:0] idx_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] green_q,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [DW-1:0] red_q,
  output logic [DW-1:0] blue_q,
  output logic [DW-1:0] scx_q,
  output logic [DW-1:0] scy_q,
  output logic [DW-1:0] ctrl_q,
  output logic          go_q,
  output logic [CW-1:0] go_code_q,
  output logic          vclr
);
  logic [CW-1:0] code_cur;
  logic [CW-1:0] code_wr;
  logic          fire;

  assign code_cur = cmd_q[CW-1:0];
  assign code_wr  = wr_data[CW-1:0];
  assign vclr     = wr_en && (wr_addr == WO_VCLR);

  // Each code has a single register whose write launches it.
  always_comb begin
    fire = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        WO_CMD:    fire = (code_wr  == OP_MOVE);
        WO_XPOS:   fire = (code_cur == OP_SPRITE);
        WO_YPOS:   fire = (code_cur == OP_RUN);
        WO_IDX_HI: fire = (code_cur == OP_LINE);
        WO_BLUE:   fire = (code_cur == OP_FILL) || (code_cur == OP_PLOT);
        default:   fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      cmd_q     <= '0;
      green_q   <= '0;
      x_q       <= '0;
      y_q       <= '0;
      red_q     <= '0;
      blue_q    <= '0;
      scx_q     <= '0;
      scy_q     <= '0;
      ctrl_q    <= '0;
      go_q      <= 1'b0;
      go_code_q <= '0;
    end else begin
      go_q <= fire;
      if (fire)
        go_code_q <= (wr_addr == WO_CMD) ? code_wr : code_cur;
      if (wr_en) begin
        case (wr_addr)
          WO_IDX_LO: idx_q[DW-1:0]  <= wr_data;
          WO_IDX_HI: idx_q[IW-1:DW] <= wr_data;
          WO_CMD:    cmd_q          <= wr_data;
          WO_GREEN:  green_q        <= wr_data;
          WO_XPOS:   x_q            <= wr_data;
          WO_YPOS:   y_q            <= wr_data;
          WO_RED:    red_q          <= wr_data;
          WO_BLUE:   blue_q         <= wr_data;
          WO_SCX:    scx_q          <= wr_data;
          WO_SCY:    scy_q          <= wr_data;
          WO_CTRL:   ctrl_q         <= wr_data;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hrif_hit_latch.sv
module hrif_hit_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] hit_x,
  input  logic [DW-1:0] hit_y,
  input  logic          ack,
  output logic          pend,
  output logic [DW-1:0] pos_x,
  output logic [DW-1:0] pos_y
);
  logic take;
  assign take = hit && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      pos_x <= '0;
      pos_y <= '0;
    end else begin
      // A pending report blocks new ones; an acknowledge drops it.
      pend <= pend ? !ack : hit;
      if (take) begin
        pos_x <= hit_x;
        pos_y <= hit_y;
      end
    end
  end
endmodule

// File: rtl/hrif_status.sv
module hrif_status
  import hrif_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          vb_set,
  input  logic          vb_clr,
  input  logic          busy,
  input  logic          line8,
  input  logic          bg_irq_en,
  input  logic          fg_pend,
  input  logic [DW-1:0] fg_x,
  input  logic [DW-1:0] fg_y,
  input  logic          bg_pend,
  input  logic [DW-1:0] bg_x,
  input  logic [DW-1:0] bg_y,
  output logic          fg_ack,
  output logic          bg_ack,
  output logic          vb_pend,
  output logic [DW-1:0] rdata_q,
  output logic          irq
);
  localparam logic [DW-1:0] BGX_MASK = ~{{(DW-BGX_DROP){1'b0}}, {BGX_DROP{1'b1}}};

  logic [DW-1:0] stat;
  logic [DW-1:0] rd_mux;

  assign fg_ack = rd_en && (rd_addr == RO_FG_Y);
  assign bg_ack = rd_en && (rd_addr == RO_BG_Y);

  always_comb begin
    stat           = '0;
    stat[ST_BUSY]  = busy;
    stat[ST_FG_N]  = !fg_pend;
    stat[ST_VB_N]  = !vb_pend;
    stat[ST_BG_N]  = !bg_pend;
    stat[ST_LINE8] = line8;
  end

  always_comb begin
    unique case (rd_addr)
      RO_FG_X: rd_mux = fg_x;
      RO_FG_Y: rd_mux = fg_y;
      RO_BG_X: rd_mux = bg_x & BGX_MASK;
      RO_BG_Y: rd_mux = bg_y;
      RO_STAT: rd_mux = stat;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_pend <= 1'b0;
      rdata_q <= '0;
    end else begin
      vb_pend <= vb_set || (vb_pend && !vb_clr);
      rdata_q <= rd_en ? rd_mux : '0;
    end
  end

  assign irq = vb_pend || fg_pend || (bg_pend && bg_irq_en);
endmodule

// File: rtl/gfx_host_regs.sv
module gfx_host_regs
  import hrif_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CW = 3,
  localparam int IW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_busy,
  input  logic          scan_line8,
  input  logic          vblank_pulse,
  input  logic          fg_hit,
  input  logic [DW-1:0] fg_hit_x,
  input  logic [DW-1:0] fg_hit_y,
  input  logic          bg_hit,
  input  logic [DW-1:0] bg_hit_x,
  input  logic [DW-1:0] bg_hit_y,
  output logic [IW-1:0] prm_index,
  output logic [DW-1:0] prm_cmd,
  output logic [DW-1:0] prm_green,
  output logic [DW-1:0] prm_x,
  output logic [DW-1:0] prm_y,
  output logic [DW-1:0] prm_red,
  output logic [DW-1:0] prm_blue,
  output logic [DW-1:0] scroll_x,
  output logic [DW-1:0] scroll_y,
  output logic [DW-1:0] ctrl,
  output logic          start,
  output logic [CW-1:0] start_code,
  output logic          irq
);
  logic          vclr;
  logic          fg_ack, bg_ack;
  logic          fg_pend, bg_pend, vb_pend;
  logic [DW-1:0] fg_x, fg_y, bg_x, bg_y;

  hrif_param_bank #(.DW(DW), .AW(AW), .CW(CW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .idx_q(prm_index), .cmd_q(prm_cmd), .green_q(prm_green),
    .x_q(prm_x), .y_q(prm_y), .red_q(prm_red), .blue_q(prm_blue),
    .scx_q(scroll_x), .scy_q(scroll_y), .ctrl_q(ctrl),
    .go_q(start), .go_code_q(start_code), .vclr(vclr)
  );

  hrif_hit_latch #(.DW(DW)) u_fg (
    .clk(clk), .rst(rst), .hit(fg_hit), .hit_x(fg_hit_x), .hit_y(fg_hit_y),
    .ack(fg_ack), .pend(fg_pend), .pos_x(fg_x), .pos_y(fg_y)
  );

  hrif_hit_latch #(.DW(DW)) u_bg (
    .clk(clk), .rst(rst), .hit(bg_hit), .hit_x(bg_hit_x), .hit_y(bg_hit_y),
    .ack(bg_ack), .pend(bg_pend), .pos_x(bg_x), .pos_y(bg_y)
  );

  hrif_status #(.DW(DW), .AW(AW)) u_stat (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_addr(bus_addr),
    .vb_set(vblank_pulse), .vb_clr(vclr), .busy(eng_busy), .line8(scan_line8),
    .bg_irq_en(ctrl[CTL_BG_EN]),
    .fg_pend(fg_pend), .fg_x(fg_x), .fg_y(fg_y),
    .bg_pend(bg_pend), .bg_x(bg_x), .bg_y(bg_y),
    .fg_ack(fg_ack), .bg_ack(bg_ack), .vb_pend(vb_pend),
    .rdata_q(bus_rdata), .irq(irq)
  );
endmodule

// File: rtl/hrif_checker.sv
module hrif_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          vblank_pulse,
  input logic          start,
  input logic          irq,
  input logic          fg_pend,
  input logic [DW-1:0] fg_x,
  input logic [DW-1:0] fg_y,
  input logic          vb_pend
);
  assert_start_after_write_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(bus_wr));

  assert_idle_codes_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'd2 && bus_wdata[2:1] == 2'b00) |=> !start);

  assert_bgx_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'd2) |=> (bus_rdata[1:0] == 2'b00));

  assert_fg_drives_irq_R8: assert property (@(posedge clk) disable iff (rst)
    fg_pend |-> irq);

  assert_vblank_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'd11 && !vblank_pulse) |=> !vb_pend);

  assert_fg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (fg_pend && !(bus_rd && bus_addr == 4'd1)) |=> (fg_pend && $stable(fg_x) && $stable(fg_y)));
endmodule

bind gfx_host_regs hrif_checker #(.DW(DW), .AW(AW)) u_hrif_checker (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank_pulse(vblank_pulse),
  .start(start), .irq(irq), .fg_pend(fg_pend), .fg_x(fg_x), .fg_y(fg_y),
  .vb_pend(vb_pend)
);

// File: tb/gfx_host_regs_tb.sv
module gfx_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        eng_busy = 1'b0, scan_line8 = 1'b0, vblank_pulse = 1'b0;
  logic        fg_hit = 1'b0, bg_hit = 1'b0;
  logic [7:0]  fg_hit_x = '0, fg_hit_y = '0, bg_hit_x = '0, bg_hit_y = '0;
  logic [15:0] prm_index;
  logic [7:0]  prm_cmd, prm_green, prm_x, prm_y, prm_red, prm_blue;
  logic [7:0]  scroll_x, scroll_y, ctrl;
  logic        start, irq;
  logic [2:0]  start_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gfx_host_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .scan_line8(scan_line8), .vblank_pulse(vblank_pulse),
    .fg_hit(fg_hit), .fg_hit_x(fg_hit_x), .fg_hit_y(fg_hit_y),
    .bg_hit(bg_hit), .bg_hit_x(bg_hit_x), .bg_hit_y(bg_hit_y),
    .prm_index(prm_index), .prm_cmd(prm_cmd), .prm_green(prm_green),
    .prm_x(prm_x), .prm_y(prm_y), .prm_red(prm_red), .prm_blue(prm_blue),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .ctrl(ctrl),
    .start(start), .start_code(start_code), .irq(irq)
  );

  // {kind(0 write,1 read), addr, data, exp_start, exp_code, exp_rdata}
  localparam int NV = 30;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 4'h2, 8'h02, 1'b0, 3'd0, 8'h00},  // R3 code 2 via CMD: no start
    {2'd0, 4'h3, 8'h11, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h6, 8'h22, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h7, 8'h33, 1'b1, 3'd2, 8'h00},  // R3 B fires 2
    {2'd0, 4'h2, 8'h03, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h5, 8'h40, 1'b0, 3'd0, 8'h00},  // R3 Y does not fire 3
    {2'd0, 4'h4, 8'h50, 1'b1, 3'd3, 8'h00},  // R3 X fires 3
    {2'd0, 4'h2, 8'h04, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h4, 8'h51, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h5, 8'h41, 1'b1, 3'd4, 8'h00},  // R3 Y fires 4
    {2'd0, 4'h2, 8'h05, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h0, 8'h10, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h1, 8'h20, 1'b1, 3'd5, 8'h00},  // R3 IH fires 5
    {2'd0, 4'h2, 8'h07, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h7, 8'h34, 1'b1, 3'd7, 8'h00},  // R3 B fires 7
    {2'd0, 4'h2, 8'h86, 1'b1, 3'd6, 8'h00},  // R2 CMD fires 6
    {2'd0, 4'h7, 8'h35, 1'b0, 3'd0, 8'h00},  // R3 B with code 6
    {2'd0, 4'h2, 8'h00, 1'b0, 3'd0, 8'h00},  // R4 code 0
    {2'd0, 4'h7, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h4, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h5, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h1, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h2, 8'h01, 1'b0, 3'd0, 8'h00},  // R4 code 1
    {2'd0, 4'h7, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h1, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd0, 4'h4, 8'h00, 1'b0, 3'd0, 8'h00},
    {2'd1, 4'h5, 8'h00, 1'b0, 3'd0, 8'h00},  // R11 read 5
    {2'd1, 4'hF, 8'h00, 1'b0, 3'd0, 8'h00},  // R11 read 15
    {2'd1, 4'h0, 8'h00, 1'b0, 3'd0, 8'h00},  // R5 no hit yet
    {2'd1, 4'h4, 8'h00, 1'b0, 3'd0, 8'h70}   // R7 idle status
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {15'd0, irq}, 16'd0);
    chk("R11 start", {15'd0, start}, 16'd0);
    chk("R11 index", prm_index, 16'd0);
    chk("R11 ctrl", {8'd0, ctrl}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      if (v[25:24] == 2'd0) begin
        wr(v[23:20], v[19:12]);
        chk("R2/R3/R4 start", {15'd0, start}, {15'd0, v[11]});
        if (v[11]) chk("R2/R3 code", {13'd0, start_code}, {13'd0, v[10:8]});
      end else begin
        rd(v[23:20], r);
        chk("R5/R7/R11 read", {8'd0, r}, {8'd0, v[7:0]});
      end
    end

    // R2 pulse lasts one cycle
    wr(4'h2, 8'h06);
    chk("R2 pulse", {15'd0, start}, 16'd1);
    @(negedge clk);
    chk("R2 one cycle", {15'd0, start}, 16'd0);

    // R1 register map (code 1 keeps all quiet)
    wr(4'h2, 8'h01);
    wr(4'h0, 8'hA5); wr(4'h1, 8'h5A); wr(4'h3, 8'h12); wr(4'h4, 8'h34);
    wr(4'h5, 8'h56); wr(4'h6, 8'h78); wr(4'h7, 8'h9A); wr(4'h8, 8'hBC);
    wr(4'h9, 8'hDE); wr(4'hA, 8'h20);
    chk("R1 index", prm_index, 16'h5AA5);
    chk("R1 cmd", {8'd0, prm_cmd}, 16'h0001);
    chk("R1 rgb", {prm_green, prm_red}, 16'h1278);
    chk("R1 blue", {8'd0, prm_blue}, 16'h009A);
    chk("R1 xy", {prm_x, prm_y}, 16'h3456);
    chk("R1 scroll", {scroll_x, scroll_y}, 16'hBCDE);
    chk("R1 ctrl", {8'd0, ctrl}, 16'h0020);

    // R7 busy and scanline bits
    eng_busy = 1'b1; scan_line8 = 1'b1;
    rd(4'h4, r);
    chk("R7 busy line", {8'd0, r}, 16'h00F8);
    eng_busy = 1'b0; scan_line8 = 1'b0;

    // R9 / R8 frame blank
    @(negedge clk); vblank_pulse = 1'b1;
    @(negedge clk); vblank_pulse = 1'b0;
    chk("R8 vblank irq", {15'd0, irq}, 16'd1);
    rd(4'h4, r);
    chk("R7 vblank bit", {8'd0, r}, 16'h0050);
    wr(4'hB, 8'h00);
    chk("R9 clear", {15'd0, irq}, 16'd0);

    // R5 / R10 foreground collision
    @(negedge clk); fg_hit = 1'b1; fg_hit_x = 8'h21; fg_hit_y = 8'h43;
    @(negedge clk); fg_hit_x = 8'h99; fg_hit_y = 8'h88;
    @(negedge clk); fg_hit = 1'b0;
    chk("R8 fg irq", {15'd0, irq}, 16'd1);
    rd(4'h0, r);
    chk("R10 held x", {8'd0, r}, 16'h0021);
    rd(4'h1, r);
    chk("R5 y", {8'd0, r}, 16'h0043);
    chk("R5 cleared", {15'd0, irq}, 16'd0);

    // R6 / R8 background collision with enable
    @(negedge clk); bg_hit = 1'b1; bg_hit_x = 8'h37; bg_hit_y = 8'h55;
    @(negedge clk); bg_hit = 1'b0;
    chk("R8 bg enabled", {15'd0, irq}, 16'd1);
    wr(4'hA, 8'h00);
    chk("R8 bg masked", {15'd0, irq}, 16'd0);
    rd(4'h4, r);
    chk("R7 bg bit", {8'd0, r}, 16'h0060);
    rd(4'h2, r);
    chk("R6 x masked", {8'd0, r}, 16'h0034);
    rd(4'h3, r);
    chk("R6 y", {8'd0, r}, 16'h0055);
    rd(4'h4, r);
    chk("R6 cleared", {8'd0, r}, 16'h0070);

    // R9 set wins over clear
    @(negedge clk);
    vblank_pulse = 1'b1; bus_wr = 1'b1; bus_addr = 4'hB; bus_wdata = 8'h00;
    @(negedge clk);
    vblank_pulse = 1'b0; bus_wr = 1'b0;
    chk("R9 set wins", {15'd0, irq}, 16'd1);

    // R11 reset clears live state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11 irq after reset", {15'd0, irq}, 16'd0);
    chk("R11 regs after reset", {prm_x, scroll_x}, 16'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule